// File: doc/BRIEF.md
# Modem Receive Status Register

This block keeps the receive-side status flags of a packet data modem. It tracks three conditions. The first is a flag that says a fresh signal-quality reading is waiting to be collected. The second is a bit that records whether the last frame sync came from a mobile or from a base station. The third follows the live end-of-packet/envelope detector. It also drives an interrupt request from these flags and their enables.

The mobile/base decision comes from the three received bits that arrive just before a frame sync. A three-stage history of the received bit stream is frozen when the sync-detected strobe fires. At the end of either sync-search task, the frozen bits are voted onto the station bit. The voting tolerates a single bit error. The quality-ready flag is set by the external quality measurement and cleared by a read of the quality register. It also rises, with no valid reading behind it, after a reset command or when power-save or transmit mode is left.

Top module: `rx_status_reg`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `dq_rdy`, `stn_type`, `eop_env` and `irq` are all 0 (with `det_in` held 0).
- R2: `rx_bit` is shifted into a 3-bit history on each `rx_bit_valid` cycle. A `sync_found` pulse freezes the history as it stands before that cycle's shift, with the earliest bit as b2 and the latest as b0. A pulse on `sfs_end` or `sfh_end` in receive mode sets `stn_type` one cycle later to 1 when at least two of (~b2, b1, b0) are 1, and to 0 otherwise. So the patterns 011, 111, 001 and 010 give 1, and 100, 000, 110 and 101 give 0.
- R3: While `tx_mode` is 1, `stn_type` reads 0 and end-of-search strobes do not change the stored station bit. The stored value reappears once `tx_mode` returns to 0.
- R4: `eop_env` equals `det_in` while `tx_mode` is 0 and is 0 while `tx_mode` is 1, with no clock delay.
- R5: A `dq_done` pulse with `tx_mode` = 0 and `psave` = 0 sets `dq_rdy` in the next cycle. A `dq_done` pulse during transmit or power-save has no effect.
- R6: A `dq_read` pulse clears `dq_rdy` in the next cycle. If `dq_done` is accepted in the same cycle as the read, `dq_rdy` stays 1.
- R7: A `reset_task` pulse sets `dq_rdy` and clears the station bit in the next cycle. A 1-to-0 change of `psave` or of `tx_mode` also sets `dq_rdy` in the next cycle.
- R8: `irq` = (`dq_rdy` AND `dq_irq_en`) OR (`eop_env` AND `det_irq_en`), with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| psave | input | 1 | Power-save mode |
| reset_task | input | 1 | Reset command strobe |
| rx_bit | input | 1 | Received data bit |
| rx_bit_valid | input | 1 | `rx_bit` is a new bit this cycle |
| sync_found | input | 1 | Frame sync detected strobe |
| sfs_end | input | 1 | End of first sync-search task |
| sfh_end | input | 1 | End of second sync-search task |
| dq_done | input | 1 | Quality reading completed |
| dq_read | input | 1 | Quality register read strobe |
| det_in | input | 1 | End-of-packet/envelope detector output |
| dq_irq_en | input | 1 | Interrupt enable for `dq_rdy` |
| det_irq_en | input | 1 | Interrupt enable for `eop_env` |
| dq_rdy | output | 1 | Quality reading ready flag |
| stn_type | output | 1 | 1 = mobile origin, 0 = base origin |
| eop_env | output | 1 | Masked detector status |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a quality completion arriving in the cycle the quality register is read. The bench drives `dq_done` and `dq_read` together and expects `dq_rdy` to stay set, because the new reading has not been collected. The second is a sync strobe coinciding with a new received bit. The bench drives both at once and expects the station decision to use the history as it stood before the shift, so the newly arrived bit is left out of the vote.

// File: rtl/rx_status_reg.sv
module rx_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_mode,
  input  logic psave,
  input  logic reset_task,
  input  logic rx_bit,
  input  logic rx_bit_valid,
  input  logic sync_found,
  input  logic sfs_end,
  input  logic sfh_end,
  input  logic dq_done,
  input  logic dq_read,
  input  logic det_in,
  input  logic dq_irq_en,
  input  logic det_irq_en,
  output logic dq_rdy,
  output logic stn_type,
  output logic eop_env,
  output logic irq
);
  localparam int HW = 3;

  logic [HW-1:0] hist, pre_sync;
  logic station, dq_q, tx_q, ps_q;
  logic vote, dq_set, dq_spur, search_end;

  assign vote = (~pre_sync[2] & pre_sync[1]) | (~pre_sync[2] & pre_sync[0])
              | (pre_sync[1] & pre_sync[0]);
  assign search_end = (sfs_end | sfh_end) & ~tx_mode;
  assign dq_set  = dq_done & ~tx_mode & ~psave;
  assign dq_spur = reset_task | (tx_q & ~tx_mode) | (ps_q & ~psave);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist     <= '0;
      pre_sync <= '0;
    end else begin
      if (rx_bit_valid) hist <= {hist[HW-2:0], rx_bit};
      if (sync_found) pre_sync <= hist;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) station <= 1'b0;
    else if (reset_task) station <= 1'b0;
    else if (search_end) station <= vote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= 1'b0;
      tx_q <= 1'b0;
      ps_q <= 1'b0;
    end else begin
      tx_q <= tx_mode;
      ps_q <= psave;
      if (dq_set || dq_spur) dq_q <= 1'b1;
      else if (dq_read) dq_q <= 1'b0;
    end
  end

  assign dq_rdy   = dq_q;
  assign stn_type = station & ~tx_mode;
  assign eop_env  = det_in & ~tx_mode;
  assign irq      = (dq_q & dq_irq_en) | (eop_env & det_irq_en);

  // R5
  dq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_done && !tx_mode && !psave) |=> dq_rdy);

  // R6
  dq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_read && !dq_done && !reset_task && !$fell(tx_mode) && !$fell(psave)) |=> !dq_rdy);

  // R7
  rst_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_task |=> (dq_rdy && !stn_type));

  // R3
  stn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfs_end && !sfh_end && !reset_task && !tx_mode) |=> (tx_mode || $stable(stn_type)));

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_rdy && dq_irq_en) || (det_in && !tx_mode && det_irq_en)) |-> irq);

  // R4
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode |-> (!eop_env && !stn_type));
endmodule

// File: tb/rx_status_reg_test.sv
module rx_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 0, psave = 0, reset_task = 0, rx_bit = 0, rx_bit_valid = 0;
  logic sync_found = 0, sfs_end = 0, sfh_end = 0, dq_done = 0, dq_read = 0;
  logic det_in = 0, dq_irq_en = 0, det_irq_en = 0;
  logic dq_rdy, stn_type, eop_env, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_status_reg uut (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .psave(psave),
    .reset_task(reset_task), .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid),
    .sync_found(sync_found), .sfs_end(sfs_end), .sfh_end(sfh_end),
    .dq_done(dq_done), .dq_read(dq_read), .det_in(det_in),
    .dq_irq_en(dq_irq_en), .det_irq_en(det_irq_en),
    .dq_rdy(dq_rdy), .stn_type(stn_type), .eop_env(eop_env), .irq(irq));

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic b);
    rx_bit = b; rx_bit_valid = 1;
    step();
    rx_bit_valid = 0;
  endtask

  task automatic search(input logic [2:0] pat, input bit use_sfh);
    push(pat[2]); push(pat[1]); push(pat[0]);
    sync_found = 1; step(); sync_found = 0;
    if (use_sfh) sfh_end = 1; else sfs_end = 1;
    step();
    sfs_end = 0; sfh_end = 0;
  endtask

  function automatic logic vote_of(input logic [2:0] p);
    int ones;
    ones = int'(!p[2]) + int'(p[1]) + int'(p[0]);
    return ones >= 2;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    #5;
    chk(dq_rdy, 0, "R1 dq_rdy in reset");
    chk(stn_type, 0, "R1 stn_type in reset");
    chk(irq, 0, "R1 irq in reset");
    rst_n = 1;
    step();
    chk(dq_rdy, 0, "R1 dq_rdy after reset");
    chk(stn_type, 0, "R1 stn_type after reset");
    chk(eop_env, 0, "R1 eop_env after reset");

    // R2 sweep of all patterns with both end strobes
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 8; p++) begin
        search(3'(p), s[0]);
        chk(stn_type, vote_of(3'(p)), "R2 station vote");
      end

    // R2 sync coinciding with a new bit: new bit excluded
    push(1); push(0); push(0);
    rx_bit = 1; rx_bit_valid = 1; sync_found = 1; step();
    rx_bit_valid = 0; sync_found = 0;
    sfs_end = 1; step(); sfs_end = 0;
    chk(stn_type, 0, "R2 sync with concurrent bit");

    // R3 transmit mode ignores search end and masks station
    for (int p = 0; p < 8; p++) begin
      search(3'(p), 0);
      tx_mode = 1; step();
      chk(stn_type, 0, "R3 station masked in tx");
      search(~3'(p), 1);
      chk(stn_type, 0, "R3 station masked in tx after search");
      tx_mode = 0; step();
      chk(stn_type, vote_of(3'(p)), "R3 station held across tx");
    end

    // R4 detector masking
    for (int t = 0; t < 2; t++)
      for (int d = 0; d < 2; d++) begin
        tx_mode = t[0]; det_in = d[0]; #1;
        chk(eop_env, d[0] & !t[0], "R4 eop_env");
      end
    det_in = 0; tx_mode = 0; step();

    // clear dq_rdy
    dq_read = 1; step(); dq_read = 0;
    chk(dq_rdy, 0, "R6 read clears");

    // R5 set in receive
    dq_done = 1; step(); dq_done = 0;
    chk(dq_rdy, 1, "R5 done sets");
    // R6 read and done together
    dq_read = 1; dq_done = 1; step(); dq_read = 0; dq_done = 0;
    chk(dq_rdy, 1, "R6 done wins over read");
    dq_read = 1; step(); dq_read = 0;
    chk(dq_rdy, 0, "R6 read clears after collision");

    // R5 ignored in tx / psave
    tx_mode = 1; step();
    dq_done = 1; step(); dq_done = 0;
    chk(dq_rdy, 0, "R5 done ignored in tx");
    tx_mode = 0; step();
    chk(dq_rdy, 1, "R7 tx fall sets");
    dq_read = 1; step(); dq_read = 0;
    psave = 1; step();
    dq_done = 1; step(); dq_done = 0;
    chk(dq_rdy, 0, "R5 done ignored in psave");
    psave = 0; step();
    chk(dq_rdy, 1, "R7 psave fall sets");

    // R7 reset task
    search(3'b011, 0);
    dq_read = 1; step(); dq_read = 0;
    chk(stn_type, 1, "R7 station before reset task");
    reset_task = 1; step(); reset_task = 0;
    chk(dq_rdy, 1, "R7 reset task sets dq_rdy");
    chk(stn_type, 0, "R7 reset task clears station");

    // R8 interrupt sweep
    for (int q = 0; q < 2; q++)
      for (int d = 0; d < 2; d++)
        for (int e = 0; e < 4; e++) begin
          dq_read = 1; step(); dq_read = 0;
          if (q == 1) begin dq_done = 1; step(); dq_done = 0; end
          det_in = d[0]; dq_irq_en = e[0]; det_irq_en = e[1]; #1;
          chk(irq, (q[0] & e[0]) | (d[0] & e[1]), "R8 irq");
          det_in = 0; dq_irq_en = 0; det_irq_en = 0;
        end

    summary();
  end
endmodule